// File: doc/BRIEF.md
# Page-mode PSRAM read controller

This block sits on the host side of an asynchronous pseudo-static RAM that has a 16-bit data bus. A host issues single-word reads and writes on a valid/ready request port, each with a word address and two byte enables. The controller turns every request into the active-low chip-enable, output-enable, write-enable and byte-lane strobes and drives the address bus. It returns read data with a one-cycle valid pulse. All memory timings are counted in clock cycles and set by parameters.

Between requests the controller keeps chip enable low. This keeps the current 16-word page open. A read that changes only the low four address bits, while that page is open, finishes in the short page-access time. A read that opens a new page uses the full random-access time. Writes always use the full write timing and close the page. Chip enable may not stay low without limit, because the memory must refresh itself. A guard counter therefore raises chip enable for one cycle before the limit can be exceeded. It does this even in the middle of a run of page reads. The next read then pays the full access time again.

Top module: `psram_page_ctrl`

## Requirements
- R1: After reset, all five memory strobes are high, the host bus driver is off, rvalid is low and req_ready is high.
- R2: A read is a random access when chip enable was high at any point since the previous read, when no read has occurred yet, or when address bits [AW-1:4] differ from those of the previous read. rvalid for a random access is seen TAA_CYC clock edges after the accepting edge.
- R3: A read is a page hit when chip enable stayed low since the previous read, no write came between, and only address bits [3:0] differ from the previous read. rvalid for a page hit is seen TAPA_CYC edges after the accepting edge.
- R4: During a write, the write-enable strobe is low for exactly TWC_CYC cycles while chip enable is low. In the cycle in which write enable rises, the host still drives the request's write data on the bus.
- R5: The first read after a write is always a random access (TAA_CYC), even within the same page.
- R6: Byte enable bit 1 controls the upper lane [15:8] through the upper-lane strobe, and bit 0 controls the lower lane [7:0] through the lower-lane strobe. A lane whose enable is 0 is not written and keeps its stored value.
- R7: In read data, a lane whose enable bit is 0 is returned as zero. A read with both enables off is still a timed access with the normal latency.
- R8: Chip enable is never low for more than TCEM_CYC consecutive cycles. During a long page run, the controller raises chip enable on its own.
- R9: The host drives the data bus only while output enable is high. Output enable and write enable are never low at the same time.
- R10: rvalid is a single-cycle pulse, and rdata is valid in that cycle.
- R11: req_ready is low while an access or a chip-enable recovery cycle is in progress. While req_ready is high, no strobe other than chip enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Host drives the data bus |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
A stale open-page record shows up on the very next read: its rvalid latency changes from TAA_CYC to TAPA_CYC or the other way, so each read's latency is compared with a page model that the bench derives from the observed chip-enable line. A low-time counter that is wrong shows up as a chip-enable low run longer than TCEM_CYC, or as a long page run in which chip enable never rises. Wrong lane or hold handling in the write path is visible one read later, as corrupted bytes in the behavioural memory. A bad capture mask is visible in the same rvalid cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WHOLD,
    ST_CEREST
  } ctrl_state_t;

  // Longest time chip enable stays low for one access (write adds a hold cycle).
  function automatic int unsigned worst_access(input int unsigned taa, input int unsigned twc);
    return (taa > twc + 1) ? taa : twc + 1;
  endfunction

  // Low-cycle count after which no new access may start.
  function automatic int unsigned cem_open_limit(input int unsigned tcem, input int unsigned taa,
                                                 input int unsigned twc);
    return tcem - worst_access(taa, twc) - 1;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/psram_acc_timer.sv
module psram_acc_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == TW'(1));
endmodule

// File: rtl/psram_cem_guard.sv
module psram_cem_guard #(
  parameter int CW    = 8,
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_low,
  output logic close_now
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (!ce_low)        low_cnt <= '0;
    else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
  end

  assign close_now = ce_low && (low_cnt >= CW'(LIMIT));
endmodule

// File: rtl/psram_page_track.sv
module psram_page_track #(
  parameter int TAGW = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic            clear,
  input  logic [TAGW-1:0] tag_in,
  output logic            hit
);
  logic            valid;
  logic [TAGW-1:0] tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
      tag   <= tag_in;
    end
  end

  assign hit = valid && (tag == tag_in);
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
  import psram_pkg::*;
#(
  parameter int AW        = 21,
  parameter int PAGE_BITS = 4,
  parameter int TAA_CYC   = 4,
  parameter int TAPA_CYC  = 2,
  parameter int TWC_CYC   = 4,
  parameter int TCEM_CYC  = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          rvalid,
  output logic [15:0]   rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);
  localparam int TAGW   = AW - PAGE_BITS;
  localparam int MAXACC = int'(worst_access(TAA_CYC, TWC_CYC));
  localparam int LIMIT  = int'(cem_open_limit(TCEM_CYC, TAA_CYC, TWC_CYC));
  localparam int TW     = $clog2(MAXACC + 1);
  localparam int CW     = $clog2(TCEM_CYC + 1);

  ctrl_state_t   state;
  logic          ce_open;
  logic [AW-1:0] addr_q;
  logic [1:0]    be_q;
  logic [15:0]   wdata_q;

  // Named internal events
  logic          ce_low, close_now, acc_start, rd_start, wr_start;
  logic          page_hit, acc_done, rd_done, page_clear;
  logic [TW-1:0] load_val;

  assign ce_low     = ~mem_ce_n;
  assign req_ready  = (state == ST_IDLE) && !close_now;
  assign acc_start  = req_ready && req_valid;
  assign rd_start   = acc_start && !req_write;
  assign wr_start   = acc_start && req_write;
  assign rd_done    = (state == ST_READ) && acc_done;
  assign page_clear = wr_start || ((state == ST_IDLE) && close_now);
  assign load_val   = req_write ? TW'(TWC_CYC) : (page_hit ? TW'(TAPA_CYC) : TW'(TAA_CYC));

  psram_acc_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(acc_start), .load_val(load_val), .done(acc_done)
  );

  psram_cem_guard #(.CW(CW), .LIMIT(LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .ce_low(ce_low), .close_now(close_now)
  );

  psram_page_track #(.TAGW(TAGW)) u_page (
    .clk(clk), .rst_n(rst_n), .set(rd_start), .clear(page_clear),
    .tag_in(req_addr[AW-1:PAGE_BITS]), .hit(page_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ce_open <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      rvalid <= rd_done;
      if (rd_done) rdata <= mem_dq_i & lane_mask(be_q);
      case (state)
        ST_IDLE: begin
          if (close_now) begin
            state   <= ST_CEREST;
            ce_open <= 1'b0;
          end else if (req_valid) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            ce_open <= 1'b1;
            state   <= req_write ? ST_WRITE : ST_READ;
          end
        end
        ST_READ:   if (acc_done) state <= ST_IDLE;
        ST_WRITE:  if (acc_done) state <= ST_WHOLD;
        ST_WHOLD:  state <= ST_IDLE;
        ST_CEREST: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  logic lanes_on;
  always_comb begin
    lanes_on  = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WHOLD);
    mem_ce_n  = !(lanes_on || ((state == ST_IDLE) && ce_open));
    mem_oe_n  = (state != ST_READ);
    mem_we_n  = (state != ST_WRITE);
    mem_ub_n  = !(lanes_on && be_q[1]);
    mem_lb_n  = !(lanes_on && be_q[0]);
    mem_dq_oe = (state == ST_WRITE) || (state == ST_WHOLD);
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk #(
  parameter int TCEM_CYC = 200
) (
  input logic clk,
  input logic rst_n,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe,
  input logic rvalid,
  input logic req_ready,
  input logic rd_start,
  input logic page_hit
);
  localparam int CW = $clog2(TCEM_CYC + 2);
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (mem_ce_n)       low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 1'b1;
  end

  assert_cem_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (low_run < CW'(TCEM_CYC)));

  assert_bus_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_rvalid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  assert_hit_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && page_hit) |-> !mem_ce_n);

  assert_strobe_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(.TCEM_CYC(TCEM_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .rvalid(rvalid),
  .req_ready(req_ready), .rd_start(rd_start), .page_hit(page_hit)
);

// File: tb/tb_psram_page_ctrl.sv
`timescale 1ns/1ps
module tb_psram_page_ctrl;
  localparam int AW = 8, TAA = 4, TAPA = 2, TWC = 3, TCEM = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic rvalid;
  logic [15:0] rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  always #10 clk = ~clk;

  psram_page_ctrl #(.AW(AW), .TAA_CYC(TAA), .TAPA_CYC(TAPA), .TWC_CYC(TWC), .TCEM_CYC(TCEM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: latches write data when write enable rises.
  logic [15:0] model_mem [256];
  logic [15:0] shadow [256];
  always @(posedge mem_we_n) begin
    if (!mem_ce_n) begin
      if (!mem_lb_n) model_mem[mem_addr][7:0]  <= mem_dq_oe ? mem_dq_o[7:0]  : 8'hxx;
      if (!mem_ub_n) model_mem[mem_addr][15:8] <= mem_dq_oe ? mem_dq_o[15:8] : 8'hxx;
    end
  end
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ?
      {mem_ub_n ? 8'hxx : model_mem[mem_addr][15:8], mem_lb_n ? 8'hxx : model_mem[mem_addr][7:0]}
      : 16'hxxxx;

  int n_cmp = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] w, input logic [1:0] be);
    masked = w & {be[1] ? 8'hff : 8'h00, be[0] ? 8'hff : 8'h00};
  endfunction

  // Port monitors
  int ce_rises = 0, low_run = 0, max_run = 0, bus_bad = 0, pulse_bad = 0, ready_bad = 0;
  logic prev_rv = 0;
  always @(negedge clk) if (rst_n) begin
    if (mem_ce_n) begin ce_rises <= ce_rises + 1; low_run <= 0; end
    else begin
      low_run <= low_run + 1;
      if (low_run + 1 > max_run) max_run <= low_run + 1;
    end
    if ((mem_dq_oe && !mem_oe_n) || (!mem_oe_n && !mem_we_n)) bus_bad <= bus_bad + 1;
    if (rvalid && prev_rv) pulse_bad <= pulse_bad + 1;
    prev_rv <= rvalid;
    if (req_ready && (!mem_we_n || !mem_oe_n || mem_dq_oe)) ready_bad <= ready_bad + 1;
  end

  // Expected page state
  bit pg_open = 0, last_wr = 0;
  logic [3:0] pg_tag = '0;
  int rise_mark = 0;

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be);
    bit hit; int lat; logic [15:0] exp_d;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    while (!req_ready) @(negedge clk);
    hit = pg_open && (pg_tag == a[7:4]) && (ce_rises == rise_mark);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rvalid && lat < 64) begin @(negedge clk); lat++; end
    if (hit) check(lat == TAPA, "R3 page-hit latency", lat, TAPA);
    else if (last_wr) check(lat == TAA, "R5 read-after-write latency", lat, TAA);
    else check(lat == TAA, "R2 random latency", lat, TAA);
    exp_d = masked(shadow[a], be);
    check(rdata === exp_d, (be == 2'b11) ? "R10 read data" : "R7 lane-masked data", rdata, exp_d);
    pg_open = 1; pg_tag = a[7:4]; rise_mark = ce_rises; last_wr = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
    int lat;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!mem_we_n && lat < 64) begin lat++; @(negedge clk); end
    check(lat == TWC, "R4 write strobe width", lat, TWC);
    check(mem_dq_oe && mem_dq_o == d && !mem_ce_n, "R4 data hold at WE rise",
          {mem_dq_oe, mem_dq_o}, {1'b1, d});
    if (be[0]) shadow[a][7:0] = d[7:0];
    if (be[1]) shadow[a][15:8] = d[15:8];
    pg_open = 0; last_wr = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int r0;
    logic [AW-1:0] last_a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 16'(i * 16'h1357) ^ 16'ha5a5;
      shadow[i]    = 16'(i * 16'h1357) ^ 16'ha5a5;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rvalid, req_ready} == 8'b11111001,
          "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rvalid, req_ready},
          8'b11111001);

    do_read(8'h23, 2'b11);          // R2 first read
    do_read(8'h25, 2'b11);          // R3 hit
    do_read(8'h2f, 2'b10);          // R3/R7 upper lane only
    do_read(8'h20, 2'b00);          // R7 both lanes off, still timed
    do_read(8'h45, 2'b11);          // R2 new page
    do_write(8'h46, 2'b01, 16'hbeef); // R6 lower lane only
    do_read(8'h46, 2'b11);          // R5 and R6 upper byte kept
    do_write(8'h47, 2'b00, 16'h1234); // R6 nothing written
    do_read(8'h47, 2'b11);
    // R8: long page run forces chip enable high on its own
    r0 = ce_rises;
    for (int i = 0; i < 25; i++) do_read({4'h6, 4'(i)}, 2'b11);
    check(ce_rises > r0, "R8 forced CE release in page run", ce_rises - r0, 1);
    // R8: idle with CE open, then read same page
    repeat (50) @(negedge clk);
    do_read(8'h63, 2'b11);

    last_a = 8'h63;
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 9) < 7) ? {last_a[7:4], 4'($urandom_range(0, 15))} : 8'($urandom);
      if ($urandom_range(0, 3) == 0) do_write(a, 2'($urandom), 16'($urandom));
      else do_read(a, 2'($urandom));
      last_a = a;
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    @(negedge clk);
    check(max_run <= TCEM, "R8 max CE low run", max_run, TCEM);
    check(bus_bad == 0, "R9 bus ownership", bus_bad, 0);
    check(pulse_bad == 0, "R10 rvalid pulse width", pulse_bad, 0);
    check(ready_bad == 0, "R11 ready only when quiet", ready_bad, 0);
    finish_run();
  end
endmodule